// File: doc/BRIEF.md
# Sampling-Clock Tuning Sequencer

This block steers the search for a good receive sampling phase inside an SD/eMMC host controller. Software starts a search by setting the Execute Tuning control bit. It then issues tuning-block reads (command index 19, or 21 for the eMMC high-speed tuning read) until the block clears that bit. For each block that comes back, a pattern checker outside the block reports pass or fail. The sequencer records that result against the phase selector currently in use, steps the selector up by one, and pulses a buffer-read-ready event. That event, not a command-complete event, tells software that the tuning read has finished.

The sequencer tracks the runs of consecutive passing phases. As soon as a run of at least `MIN_RUN` phases has been closed, it ends the search successfully. A run is closed by a failing phase, or by the run reaching the last phase. On success it clears Execute Tuning, sets Sampling Clock Select and parks the phase selector on the centre of the longest run. The search fails if the sweep passes the last phase without success, or if `MAX_ITER` tuning commands have been accepted. On failure the block clears Execute Tuning and leaves the fixed clock selected. Software learns the outcome only by polling those two bits.

States: `S_IDLE` (no search running), `S_WAIT_CMD` (search running, awaiting a tuning command), `S_WAIT_BLK` (command accepted, awaiting its data block) and `S_EVAL` (one cycle to judge the window). Transitions:
- start: `S_IDLE`→`S_WAIT_CMD`.
- accept: `S_WAIT_CMD`→`S_WAIT_BLK`.
- receive: `S_WAIT_BLK`→`S_EVAL`.
- continue: `S_EVAL`→`S_WAIT_CMD`.
- finish, on success or failure: `S_EVAL`→`S_IDLE`.
- soft reset: any state→`S_IDLE`.

Top module: `tune_seq`

## Requirements
- R1: A control write with `ctrl_exec`=1 while idle sets `exec_tuning` to 1, clears `sclk_sel`, and sets `phase_sel` and `iter_cnt` to 0 after the next clock edge.
- R2: While a search runs, only `cmd_index` values 19 and 21 are accepted as tuning commands, and each acceptance increments `iter_cnt`. Any other index leaves `iter_cnt` unchanged.
- R3: On acceptance, `blk_bytes` becomes 128 for index 21 when `bus_8bit`=1. It becomes 64 in every other case, including index 19 on an 8-bit bus. The reset value is 64.
- R4: For a `blk_done` pulse after an accepted command, `rd_ready` is high for exactly the following cycle, and `phase_sel` advances by one at the same edge.
- R5: Success is declared when the best passing run is at least `MIN_RUN` (default 4) long and either the newest result failed or the newest result was at the last phase. Success shows one cycle after `rd_ready`: `exec_tuning`=0, `sclk_sel`=1, and `phase_sel` = start of the longest run + (length−1)/2, rounded down.
- R6: If the result for the last phase (31) arrives without success, the search fails: `exec_tuning`=0, `sclk_sel`=0, `phase_sel`=0.
- R7: If `MAX_ITER` (default 40) commands have been accepted without success, the search fails the same way as R6, with `iter_cnt` holding `MAX_ITER`.
- R8: While idle, a control write with `ctrl_sclk`=0 clears `sclk_sel` and `phase_sel`. Software can never set `sclk_sel` to 1.
- R9: `sw_reset` clears `exec_tuning`, `sclk_sel`, `phase_sel` and `iter_cnt` together at the next edge and aborts any search.
- R10: Control writes while `exec_tuning`=1 have no effect; writing 0 to Execute Tuning does not stop a search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous software reset of the tuning state |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_exec | input | 1 | Written value of Execute Tuning |
| ctrl_sclk | input | 1 | Written value of Sampling Clock Select |
| cmd_issue | input | 1 | One-cycle pulse: a command is being issued |
| cmd_index | input | 6 | Index of the command being issued |
| bus_8bit | input | 1 | Data bus is 8 bits wide |
| blk_done | input | 1 | One-cycle pulse: tuning block fully received |
| blk_pass | input | 1 | Pattern checker verdict for that block |
| exec_tuning | output | 1 | Execute Tuning bit |
| sclk_sel | output | 1 | Sampling Clock Select bit (1 = tuned clock) |
| phase_sel | output | PHASE_W (5) | Sampling phase index to the delay line |
| iter_cnt | output | ITER_W (6) | Tuning commands accepted in this search |
| blk_bytes | output | 8 | Expected tuning block length in bytes |
| rd_ready | output | 1 | Buffer-read-ready event pulse |

## Verification
The hardest situation to reach from the ports is the iteration-limit failure. With the default limit of 40 and 32 phases, the sweep always reaches the last phase first, so that failure can never be seen. The bench therefore drives a second instance, built with a limit of 10, from the same stimulus, and feeds it only passing blocks. The run never closes, so only the command count can end the search. A table of pass/fail masks over the 32 phases covers these cases:
- windows at the low edge of the sweep;
- windows at the high edge;
- a window in the middle;
- a short run ahead of a qualifying run;
- two short runs that never qualify.

// File: rtl/tune_pkg.sv
package tune_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT_CMD,
        S_WAIT_BLK,
        S_EVAL
    } tune_state_e;

    localparam logic [5:0] IDX_TUNE_SD   = 6'd19;
    localparam logic [5:0] IDX_TUNE_MMC  = 6'd21;
    localparam logic [7:0] BLK_STD_BYTES = 8'd64;
    localparam logic [7:0] BLK_WIDE_BYTES = 8'd128;
endpackage

// File: rtl/tune_cmd_filter.sv
module tune_cmd_filter
    import tune_pkg::*;
(
    input  logic [5:0] cmd_index,
    input  logic       bus_8bit,
    output logic       is_tune,
    output logic [7:0] bytes
);
    always_comb begin
        is_tune = (cmd_index == IDX_TUNE_SD) || (cmd_index == IDX_TUNE_MMC);
        if ((cmd_index == IDX_TUNE_MMC) && bus_8bit)
            bytes = BLK_WIDE_BYTES;
        else
            bytes = BLK_STD_BYTES;
    end
endmodule

// File: rtl/tune_iter_ctr.sv
module tune_iter_ctr #(
    parameter int MAX_ITER = 40,
    localparam int ITER_W = $clog2(MAX_ITER + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ITER_W-1:0] count,
    output logic              at_limit
);
    localparam logic [ITER_W-1:0] LIMIT = ITER_W'(MAX_ITER);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc && (count != LIMIT))
            count <= count + 1'b1;
    end

    assign at_limit = (count == LIMIT);

    assert_iter_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIMIT);
    assert_iter_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/tune_window.sv
module tune_window #(
    parameter int PHASE_W = 5,
    localparam int LEN_W = PHASE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               upd,
    input  logic               pass,
    input  logic [PHASE_W-1:0] phase,
    output logic [LEN_W-1:0]   best_len,
    output logic [PHASE_W-1:0] centre,
    output logic               last_pass,
    output logic               at_end
);
    logic [LEN_W-1:0]   run_len;
    logic [PHASE_W-1:0] run_start;
    logic [PHASE_W-1:0] best_start;
    logic [LEN_W-1:0]   nrun;
    logic [PHASE_W-1:0] nstart;
    logic [LEN_W-1:0]   half;

    always_comb begin
        nrun   = run_len + 1'b1;
        nstart = (run_len == '0) ? phase : run_start;
        half   = LEN_W'(best_len - 1'b1) >> 1;
        centre = best_start + half[PHASE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len    <= '0;
            run_start  <= '0;
            best_len   <= '0;
            best_start <= '0;
            last_pass  <= 1'b0;
            at_end     <= 1'b0;
        end else if (clr) begin
            run_len    <= '0;
            run_start  <= '0;
            best_len   <= '0;
            best_start <= '0;
            last_pass  <= 1'b0;
            at_end     <= 1'b0;
        end else if (upd) begin
            last_pass <= pass;
            at_end    <= (phase == {PHASE_W{1'b1}});
            if (pass) begin
                run_len   <= nrun;
                run_start <= nstart;
                if (nrun > best_len) begin
                    best_len   <= nrun;
                    best_start <= nstart;
                end
            end else begin
                run_len <= '0;
            end
        end
    end

    assert_best_covers_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        best_len >= run_len);
    assert_best_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !$past(clr)) |-> best_len >= $past(best_len));
endmodule

// File: rtl/tune_seq.sv
module tune_seq
    import tune_pkg::*;
#(
    parameter int PHASE_W  = 5,
    parameter int MAX_ITER = 40,
    parameter int MIN_RUN  = 4,
    localparam int ITER_W  = $clog2(MAX_ITER + 1),
    localparam int LEN_W   = PHASE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_reset,
    input  logic               ctrl_wr,
    input  logic               ctrl_exec,
    input  logic               ctrl_sclk,
    input  logic               cmd_issue,
    input  logic [5:0]         cmd_index,
    input  logic               bus_8bit,
    input  logic               blk_done,
    input  logic               blk_pass,
    output logic               exec_tuning,
    output logic               sclk_sel,
    output logic [PHASE_W-1:0] phase_sel,
    output logic [ITER_W-1:0]  iter_cnt,
    output logic [7:0]         blk_bytes,
    output logic               rd_ready
);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_RUN);

    tune_state_e state_q, state_d;

    logic               is_tune;
    logic [7:0]         cmd_bytes;
    logic               start_req, untune_req, cmd_ok, blk_ok;
    logic               finish_ok, finish_fail;
    logic               iter_lim;
    logic               win_clr;
    logic [LEN_W-1:0]   best_len;
    logic [PHASE_W-1:0] centre;
    logic               last_pass, at_end;

    tune_cmd_filter u_filter (
        .cmd_index (cmd_index),
        .bus_8bit  (bus_8bit),
        .is_tune   (is_tune),
        .bytes     (cmd_bytes)
    );

    tune_iter_ctr #(.MAX_ITER(MAX_ITER)) u_iter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (win_clr),
        .inc      (cmd_ok),
        .count    (iter_cnt),
        .at_limit (iter_lim)
    );

    tune_window #(.PHASE_W(PHASE_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (win_clr),
        .upd       (blk_ok),
        .pass      (blk_pass),
        .phase     (phase_sel),
        .best_len  (best_len),
        .centre    (centre),
        .last_pass (last_pass),
        .at_end    (at_end)
    );

    always_comb begin
        start_req   = !sw_reset && ctrl_wr && ctrl_exec && (state_q == S_IDLE);
        untune_req  = !sw_reset && ctrl_wr && !ctrl_exec && !ctrl_sclk && (state_q == S_IDLE);
        cmd_ok      = !sw_reset && cmd_issue && is_tune && (state_q == S_WAIT_CMD);
        blk_ok      = !sw_reset && blk_done && (state_q == S_WAIT_BLK);
        win_clr     = sw_reset || start_req;
        finish_ok   = (state_q == S_EVAL) && (best_len >= MIN_LEN) && (!last_pass || at_end);
        finish_fail = (state_q == S_EVAL) && !finish_ok && (at_end || iter_lim);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_req) state_d = S_WAIT_CMD;
            S_WAIT_CMD: if (cmd_ok) state_d = S_WAIT_BLK;
            S_WAIT_BLK: if (blk_ok) state_d = S_EVAL;
            S_EVAL:     state_d = (finish_ok || finish_fail) ? S_IDLE : S_WAIT_CMD;
        endcase
        if (sw_reset) state_d = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_tuning <= 1'b0;
            sclk_sel    <= 1'b0;
            phase_sel   <= '0;
            blk_bytes   <= BLK_STD_BYTES;
            rd_ready    <= 1'b0;
        end else if (sw_reset) begin
            exec_tuning <= 1'b0;
            sclk_sel    <= 1'b0;
            phase_sel   <= '0;
            rd_ready    <= 1'b0;
        end else begin
            rd_ready <= blk_ok;
            if (start_req) begin
                exec_tuning <= 1'b1;
                sclk_sel    <= 1'b0;
                phase_sel   <= '0;
            end else if (untune_req) begin
                sclk_sel  <= 1'b0;
                phase_sel <= '0;
            end
            if (cmd_ok)
                blk_bytes <= cmd_bytes;
            if (blk_ok)
                phase_sel <= phase_sel + 1'b1;
            if (finish_ok) begin
                exec_tuning <= 1'b0;
                sclk_sel    <= 1'b1;
                phase_sel   <= centre;
            end else if (finish_fail) begin
                exec_tuning <= 1'b0;
                sclk_sel    <= 1'b0;
                phase_sel   <= '0;
            end
        end
    end

    assert_sclk_only_on_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_sel) |-> $fell(exec_tuning));
    assert_exec_falls_from_eval_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(exec_tuning) && !$past(sw_reset)) |-> $past(state_q == S_EVAL));
    assert_ready_after_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> $past(state_q == S_WAIT_BLK && blk_done));
    assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EVAL) |-> (phase_sel == $past(phase_sel) + 1'b1));
    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (!exec_tuning && !sclk_sel && phase_sel == '0 && iter_cnt == '0));
    assert_exec_matches_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        exec_tuning == (state_q != S_IDLE));
endmodule

// File: tb/tune_seq_tb_top.sv
`timescale 1ns/1ps
module tune_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_reset = 1'b0, ctrl_wr = 1'b0, ctrl_exec = 1'b0, ctrl_sclk = 1'b0;
    logic cmd_issue = 1'b0, bus_8bit = 1'b0, blk_done = 1'b0, blk_pass = 1'b0;
    logic [5:0] cmd_index = 6'd0;

    logic       exec_tuning, sclk_sel, rd_ready;
    logic [4:0] phase_sel;
    logic [5:0] iter_cnt;
    logic [7:0] blk_bytes;

    logic       lim_exec, lim_sclk, lim_rd;
    logic [4:0] lim_phase;
    logic [3:0] lim_iter;
    logic [7:0] lim_bytes;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    tune_seq dut_i (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .ctrl_wr(ctrl_wr),
        .ctrl_exec(ctrl_exec), .ctrl_sclk(ctrl_sclk), .cmd_issue(cmd_issue),
        .cmd_index(cmd_index), .bus_8bit(bus_8bit), .blk_done(blk_done),
        .blk_pass(blk_pass), .exec_tuning(exec_tuning), .sclk_sel(sclk_sel),
        .phase_sel(phase_sel), .iter_cnt(iter_cnt), .blk_bytes(blk_bytes),
        .rd_ready(rd_ready)
    );

    tune_seq #(.MAX_ITER(10)) dut_lim_i (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .ctrl_wr(ctrl_wr),
        .ctrl_exec(ctrl_exec), .ctrl_sclk(ctrl_sclk), .cmd_issue(cmd_issue),
        .cmd_index(cmd_index), .bus_8bit(bus_8bit), .blk_done(blk_done),
        .blk_pass(blk_pass), .exec_tuning(lim_exec), .sclk_sel(lim_sclk),
        .phase_sel(lim_phase), .iter_cnt(lim_iter), .blk_bytes(lim_bytes),
        .rd_ready(lim_rd)
    );

    typedef struct packed {
        logic [31:0] mask;
        logic        ok;
        logic [4:0]  phase;
        logic [5:0]  blocks;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{mask: 32'h0000_0FF0, ok: 1'b1, phase: 5'd7,  blocks: 6'd13},
        '{mask: 32'h0000_7C1C, ok: 1'b1, phase: 5'd12, blocks: 6'd16},
        '{mask: 32'h0000_0000, ok: 1'b0, phase: 5'd0,  blocks: 6'd32},
        '{mask: 32'hFC00_0000, ok: 1'b1, phase: 5'd28, blocks: 6'd32},
        '{mask: 32'h0000_000F, ok: 1'b1, phase: 5'd1,  blocks: 6'd5},
        '{mask: 32'h0070_00E0, ok: 1'b0, phase: 5'd0,  blocks: 6'd32}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic ex, input logic sc);
        ctrl_wr = 1'b1; ctrl_exec = ex; ctrl_sclk = sc;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_exec = 1'b0; ctrl_sclk = 1'b0;
    endtask

    task automatic do_cmd(input logic [5:0] idx, input logic b8);
        cmd_issue = 1'b1; cmd_index = idx; bus_8bit = b8;
        @(negedge clk);
        cmd_issue = 1'b0; cmd_index = 6'd0; bus_8bit = 1'b0;
    endtask

    task automatic do_blk(input logic p, output logic rdy);
        blk_done = 1'b1; blk_pass = p;
        @(negedge clk);
        blk_done = 1'b0; blk_pass = 1'b0;
        rdy = rd_ready;
        @(negedge clk);
    endtask

    task automatic soft_reset();
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic rdy;
        int   n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R1 reset exec", exec_tuning, 0);
        chk("R1 reset sclk", sclk_sel, 0);
        chk("R1 reset phase", phase_sel, 0);
        chk("R3 reset bytes", blk_bytes, 64);

        // Table of pass masks
        for (int v = 0; v < 6; v++) begin
            ctrl_write(1'b1, 1'b0);
            chk("R1 start exec", exec_tuning, 1);
            chk("R1 start iter", iter_cnt, 0);
            n = 0;
            for (int k = 0; k < 40; k++) begin
                do_cmd(6'd19, 1'b0);
                do_blk(VECS[v].mask[k[4:0]], rdy);
                n++;
                chk("R4 rd_ready pulse", rdy, 1);
                chk("R4 single pulse", rd_ready, 0);
                if (!exec_tuning) break;
                chk("R4 phase step", phase_sel, (k + 1) % 32);
            end
            chk("R5 R6 blocks used", n, VECS[v].blocks);
            chk("R5 R6 exec cleared", exec_tuning, 0);
            chk("R5 R6 sclk", sclk_sel, VECS[v].ok);
            chk("R5 R6 phase", phase_sel, VECS[v].phase);
        end

        // R8: after a failed run sclk=0; run a passing one then untune
        ctrl_write(1'b1, 1'b0);
        for (int k = 0; k < 13; k++) begin
            do_cmd(6'd19, 1'b0);
            do_blk(VECS[0].mask[k], rdy);
        end
        chk("R5 tuned again", sclk_sel, 1);
        ctrl_write(1'b0, 1'b1);
        chk("R8 software cannot set/keep via write 1", sclk_sel, 1);
        ctrl_write(1'b0, 1'b0);
        chk("R8 untune sclk", sclk_sel, 0);
        chk("R8 untune phase", phase_sel, 0);
        ctrl_write(1'b0, 1'b1);
        chk("R8 write 1 ignored", sclk_sel, 0);

        // R2, R3, R10 directed
        ctrl_write(1'b1, 1'b0);
        do_cmd(6'd17, 1'b1);
        chk("R2 non-tuning index ignored", iter_cnt, 0);
        do_cmd(6'd21, 1'b1);
        chk("R2 index 21 counted", iter_cnt, 1);
        chk("R3 index 21 8-bit bytes", blk_bytes, 128);
        do_blk(1'b0, rdy);
        do_cmd(6'd19, 1'b1);
        chk("R3 index 19 8-bit bytes", blk_bytes, 64);
        do_blk(1'b0, rdy);
        do_cmd(6'd21, 1'b0);
        chk("R3 index 21 4-bit bytes", blk_bytes, 64);
        chk("R2 iter after three", iter_cnt, 3);
        do_blk(1'b1, rdy);
        ctrl_write(1'b0, 1'b0);
        chk("R10 exec write ignored", exec_tuning, 1);
        chk("R10 phase untouched", phase_sel, 3);

        // R9 soft reset mid-search
        do_cmd(6'd19, 1'b0);
        soft_reset();
        chk("R9 exec", exec_tuning, 0);
        chk("R9 sclk", sclk_sel, 0);
        chk("R9 phase", phase_sel, 0);
        chk("R9 iter", iter_cnt, 0);

        // R7 iteration limit on the instance built with a limit of 10
        ctrl_write(1'b1, 1'b0);
        for (int k = 0; k < 10; k++) begin
            do_cmd(6'd19, 1'b0);
            do_blk(1'b1, rdy);
        end
        chk("R7 limit exec", lim_exec, 0);
        chk("R7 limit sclk", lim_sclk, 0);
        chk("R7 limit phase", lim_phase, 0);
        chk("R7 limit iter", lim_iter, 10);
        chk("R7 default still running", exec_tuning, 1);
        soft_reset();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule